// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Burst Address Generator

This block produces the read burst requests that refill a display's pixel path from memory. Two frame-buffer channels each have a start address and a ceiling address. The ceiling is the byte address of the last byte in the region. The generator walks the active channel from its start to its ceiling in bursts of a programmed word count. When that channel is done it pulses a completion event for it, then moves to the next channel. Dual-buffer mode sends it to the other channel; with dual-buffer mode off it returns to channel 0.

Each channel's start and ceiling are latched at the moment the channel's pass begins. Software can therefore rewrite the idle channel while the other one is being fetched, and the new values are picked up on that channel's next pass. Three load modes are supported, selected by a two-bit code:
- Code 0 fetches a palette pass over the channel 0 region, then continues with data passes.
- Code 1 fetches the palette pass only.
- Code 2 goes straight to data passes.

Requests leave on a valid/ready handshake. A new request is issued only while the downstream FIFO reports at least a threshold of free words.

Top module: `fbuf_pingpong_fetch`

## Requirements
- R1: After reset, `req_valid`, `frame0_done`, `frame1_done` and `pal_done` are all low.
- R2: Burst code 0, 1, 2, 3 and 4 sets the maximum request length to 1, 2, 4, 8 and 16 words respectively; no request is longer than the selected size.
- R3: Burst codes 5 to 7, or load mode code 3, raise `cfg_bad`, and a run request made while `cfg_bad` is high issues no request.
- R4: The first request of a pass carries the channel start address, and each following request starts at the previous address plus its length times the word size (4 bytes).
- R5: The last burst of a pass is shortened so that it ends exactly at the ceiling byte. The request lengths of a pass add up to (ceiling − start + 1) / 4 words.
- R6: One cycle after the handshake of a channel's last request, that channel's done pulse is high for one cycle. `frame0_done` is for channel 0 and `frame1_done` for channel 1; at most one event is high at a time.
- R7: With `dual_en` high, data passes alternate channel 0, channel 1, channel 0, and so on. With it low, every data pass uses channel 0.
- R8: A channel's start and ceiling are captured when its pass begins. A write to an idle channel is used on that channel's next pass, and a write to the active channel does not change the pass in progress.
- R9: In palette-only mode (code 1), the block fetches the channel 0 region once, pulses `pal_done`, and issues nothing more until `run` is lowered.
- R10: In palette-then-data mode (code 0), the palette pass over channel 0 is followed by `pal_done` and then data passes starting at channel 0, whose region is captured anew.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_len` hold steady.
- R12: No new request is raised while `fifo_free` is below `fifo_thresh`.
- R13: Lowering `run` stops the fetch at a request boundary: a pending request still completes its handshake, and no further request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Start and keep fetching while high |
| dual_en | input | 1 | Alternate between the two channels |
| burst_code | input | 3 | Burst size code, 0 to 4 legal |
| load_mode | input | 2 | 0 palette then data, 1 palette only, 2 data only |
| fifo_thresh | input | THW | Minimum free FIFO words before a request |
| fifo_free | input | THW | Free words currently in the pixel FIFO |
| ch0_start | input | AW | Channel 0 first byte address |
| ch0_ceil | input | AW | Channel 0 last byte address |
| ch1_start | input | AW | Channel 1 first byte address |
| ch1_ceil | input | AW | Channel 1 last byte address |
| req_ready | input | 1 | Memory side accepts the request |
| req_valid | output | 1 | Request present |
| req_addr | output | AW | Request byte address |
| req_len | output | 5 | Request length in words, 1 to 16 |
| cfg_bad | output | 1 | Burst code or load mode illegal |
| frame0_done | output | 1 | Channel 0 pass finished |
| frame1_done | output | 1 | Channel 1 pass finished |
| pal_done | output | 1 | Palette pass finished |

## Verification
The bench builds the block with 16-bit addresses, a 4-byte word and a 6-bit FIFO level. The narrow address keeps every region small enough to walk burst by burst. It sweeps all five legal burst sizes against region sizes from one to nine words, so every way a region can end — on a full burst or on a shortened one — is reached. The small FIFO width puts the threshold gate and the rejected codes within a few cycles of a run start. The bench also covers channel alternation, mid-pass reprogramming, the palette modes and backpressure.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int FBG_LEN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAL  = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } fbg_state_e;

    localparam logic [1:0] LM_PAL_DATA  = 2'd0;
    localparam logic [1:0] LM_PAL_ONLY  = 2'd1;
    localparam logic [1:0] LM_DATA_ONLY = 2'd2;

    function automatic logic [FBG_LEN_W-1:0] burst_words(input logic [2:0] code);
        logic [FBG_LEN_W-1:0] w;
        if (code <= 3'd4) w = FBG_LEN_W'(1) << code;
        else              w = '0;
        return w;
    endfunction

endpackage

// File: rtl/fbg_cfg_decode.sv
module fbg_cfg_decode
    import fbg_pkg::*;
(
    input  logic [2:0]           burst_code,
    input  logic [1:0]           load_mode,
    output logic [FBG_LEN_W-1:0] bw,
    output logic                 cfg_ok
);
    logic code_ok;
    logic mode_ok;

    always_comb begin
        bw      = burst_words(burst_code);
        code_ok = (bw != '0);
        mode_ok = (load_mode != 2'd3);
        cfg_ok  = code_ok && mode_ok;
    end
endmodule

// File: rtl/fbg_burst_calc.sv
module fbg_burst_calc
    import fbg_pkg::*;
#(
    parameter int AW = 32,
    parameter int WB = 4
) (
    input  logic [AW-1:0]        addr,
    input  logic [AW-1:0]        ceil,
    input  logic [FBG_LEN_W-1:0] bw,
    output logic [FBG_LEN_W-1:0] len,
    output logic                 last,
    output logic [AW-1:0]        next_addr
);
    localparam int WSH = $clog2(WB);

    logic [AW-1:0] span;
    logic [AW-1:0] rem_m1;
    logic [AW-1:0] bw_ext;

    always_comb begin
        span      = ceil - addr;
        rem_m1    = span >> WSH;
        bw_ext    = AW'(bw);
        last      = (rem_m1 < bw_ext);
        len       = last ? (rem_m1[FBG_LEN_W-1:0] + FBG_LEN_W'(1)) : bw;
        next_addr = addr + (AW'(len) << WSH);
    end
endmodule

// File: rtl/fbg_seq.sv
module fbg_seq
    import fbg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int WB  = 4,
    parameter int THW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 dual_en,
    input  logic                 cfg_ok,
    input  logic [FBG_LEN_W-1:0] bw_in,
    input  logic [1:0]           mode_in,
    input  logic [THW-1:0]       fifo_thresh,
    input  logic [THW-1:0]       fifo_free,
    input  logic [AW-1:0]        ch0_start,
    input  logic [AW-1:0]        ch0_ceil,
    input  logic [AW-1:0]        ch1_start,
    input  logic [AW-1:0]        ch1_ceil,
    input  logic                 req_ready,
    input  logic [FBG_LEN_W-1:0] calc_len,
    input  logic                 calc_last,
    input  logic [AW-1:0]        calc_next,
    output logic [AW-1:0]        cur_addr,
    output logic [AW-1:0]        cur_ceil,
    output logic [FBG_LEN_W-1:0] cur_bw,
    output logic                 req_valid,
    output logic [AW-1:0]        req_addr,
    output logic [FBG_LEN_W-1:0] req_len,
    output logic                 frame0_done,
    output logic                 frame1_done,
    output logic                 pal_done
);
    localparam int WSH = $clog2(WB);

    typedef struct packed {
        fbg_state_e           st;
        logic                 chan;
        logic [1:0]           mode;
        logic [FBG_LEN_W-1:0] bw;
        logic [AW-1:0]        addr;
        logic [AW-1:0]        ceil;
        logic                 vld;
        logic [AW-1:0]        raddr;
        logic [FBG_LEN_W-1:0] rlen;
        logic                 rlast;
        logic                 f0;
        logic                 f1;
        logic                 pd;
    } seq_s;

    seq_s q, d;
    logic nxt_chan;

    always_comb begin
        d        = q;
        d.f0     = 1'b0;
        d.f1     = 1'b0;
        d.pd     = 1'b0;
        nxt_chan = dual_en ? ~q.chan : 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (run && cfg_ok) begin
                    d.mode = mode_in;
                    d.bw   = bw_in;
                    d.chan = 1'b0;
                    d.addr = ch0_start;
                    d.ceil = ch0_ceil;
                    d.st   = (mode_in == LM_DATA_ONLY) ? ST_DATA : ST_PAL;
                end
            end
            ST_PAL, ST_DATA: begin
                if (q.vld) begin
                    if (req_ready) begin
                        d.vld = 1'b0;
                        if (q.rlast) begin
                            if (q.st == ST_PAL) begin
                                d.pd = 1'b1;
                                if (q.mode == LM_PAL_ONLY) begin
                                    d.st = ST_HOLD;
                                end else begin
                                    d.st   = ST_DATA;
                                    d.chan = 1'b0;
                                    d.addr = ch0_start;
                                    d.ceil = ch0_ceil;
                                end
                            end else begin
                                d.f0   = ~q.chan;
                                d.f1   = q.chan;
                                d.chan = nxt_chan;
                                d.addr = nxt_chan ? ch1_start : ch0_start;
                                d.ceil = nxt_chan ? ch1_ceil  : ch0_ceil;
                            end
                        end
                    end
                end else if (!run) begin
                    d.st = ST_IDLE;
                end else if (fifo_free >= fifo_thresh) begin
                    d.vld   = 1'b1;
                    d.raddr = q.addr;
                    d.rlen  = calc_len;
                    d.rlast = calc_last;
                    d.addr  = calc_next;
                end
            end
            ST_HOLD: begin
                if (!run) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur_addr    = q.addr;
    assign cur_ceil    = q.ceil;
    assign cur_bw      = q.bw;
    assign req_valid   = q.vld;
    assign req_addr    = q.raddr;
    assign req_len     = q.rlen;
    assign frame0_done = q.f0;
    assign frame1_done = q.f1;
    assign pal_done    = q.pd;

    logic [AW:0] req_end;
    assign req_end = {1'b0, q.raddr} + ({1'b0, AW'(q.rlen)} << WSH) - 1'b1;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R11
    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && req_len <= q.bw)); // R2
    AST_NO_PAST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_end <= {1'b0, q.ceil})); // R5
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame0_done, frame1_done, pal_done})); // R6
    AST_THRESH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(fifo_free >= fifo_thresh)); // R12
    AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !cfg_ok) |=> !req_valid); // R3
endmodule

// File: rtl/fbuf_pingpong_fetch.sv
module fbuf_pingpong_fetch
    import fbg_pkg::*;
#(
    parameter int AW  = 32,
    parameter int WB  = 4,
    parameter int THW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 dual_en,
    input  logic [2:0]           burst_code,
    input  logic [1:0]           load_mode,
    input  logic [THW-1:0]       fifo_thresh,
    input  logic [THW-1:0]       fifo_free,
    input  logic [AW-1:0]        ch0_start,
    input  logic [AW-1:0]        ch0_ceil,
    input  logic [AW-1:0]        ch1_start,
    input  logic [AW-1:0]        ch1_ceil,
    input  logic                 req_ready,
    output logic                 req_valid,
    output logic [AW-1:0]        req_addr,
    output logic [FBG_LEN_W-1:0] req_len,
    output logic                 cfg_bad,
    output logic                 frame0_done,
    output logic                 frame1_done,
    output logic                 pal_done
);
    logic [FBG_LEN_W-1:0] bw_dec;
    logic                 cfg_ok;
    logic [AW-1:0]        cur_addr, cur_ceil, calc_next;
    logic [FBG_LEN_W-1:0] cur_bw, calc_len;
    logic                 calc_last;

    fbg_cfg_decode u_dec (
        .burst_code (burst_code),
        .load_mode  (load_mode),
        .bw         (bw_dec),
        .cfg_ok     (cfg_ok)
    );

    fbg_burst_calc #(.AW(AW), .WB(WB)) u_calc (
        .addr      (cur_addr),
        .ceil      (cur_ceil),
        .bw        (cur_bw),
        .len       (calc_len),
        .last      (calc_last),
        .next_addr (calc_next)
    );

    fbg_seq #(.AW(AW), .WB(WB), .THW(THW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .dual_en     (dual_en),
        .cfg_ok      (cfg_ok),
        .bw_in       (bw_dec),
        .mode_in     (load_mode),
        .fifo_thresh (fifo_thresh),
        .fifo_free   (fifo_free),
        .ch0_start   (ch0_start),
        .ch0_ceil    (ch0_ceil),
        .ch1_start   (ch1_start),
        .ch1_ceil    (ch1_ceil),
        .req_ready   (req_ready),
        .calc_len    (calc_len),
        .calc_last   (calc_last),
        .calc_next   (calc_next),
        .cur_addr    (cur_addr),
        .cur_ceil    (cur_ceil),
        .cur_bw      (cur_bw),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .frame0_done (frame0_done),
        .frame1_done (frame1_done),
        .pal_done    (pal_done)
    );

    assign cfg_bad = ~cfg_ok;
endmodule

// File: tb/sim_fbuf_pingpong_fetch.sv
module sim_fbuf_pingpong_fetch;
    localparam int AW  = 16;
    localparam int WB  = 4;
    localparam int THW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, dual_en = 1'b0, req_ready = 1'b1;
    logic [2:0] burst_code = 3'd0;
    logic [1:0] load_mode = 2'd2;
    logic [THW-1:0] fifo_thresh = '0, fifo_free = '1;
    logic [AW-1:0] ch0_start = '0, ch0_ceil = '0, ch1_start = '0, ch1_ceil = '0;
    logic req_valid, cfg_bad, frame0_done, frame1_done, pal_done;
    logic [AW-1:0] req_addr;
    logic [4:0] req_len;

    int n_tests = 0;
    int n_fail = 0;
    int mod_sel = 0;

    always #10 clk = ~clk;

    fbuf_pingpong_fetch #(.AW(AW), .WB(WB), .THW(THW)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .dual_en(dual_en),
        .burst_code(burst_code), .load_mode(load_mode),
        .fifo_thresh(fifo_thresh), .fifo_free(fifo_free),
        .ch0_start(ch0_start), .ch0_ceil(ch0_ceil),
        .ch1_start(ch1_start), .ch1_ceil(ch1_ceil),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .cfg_bad(cfg_bad), .frame0_done(frame0_done),
        .frame1_done(frame1_done), .pal_done(pal_done)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(input string tag);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!req_valid && k < 200);
        chk(req_valid, tag, 0, 1);
    endtask

    task automatic apply_mod();
        if (mod_sel == 1) begin
            ch1_start = 16'h3000; ch1_ceil = 16'h3000 + 16'd11;
            ch0_start = 16'h4000; ch0_ceil = 16'h4000 + 16'd19;
        end else if (mod_sel == 2) begin
            ch0_start = 16'h0800; ch0_ceil = 16'h0800 + 16'd27;
        end
    endtask

    // kind: 0 frame0, 1 frame1, 2 palette
    task automatic expect_pass(input int s, input int e, input int bw, input int kind, input bit do_mod);
        int a = s;
        int words = 0;
        bit first = 1;
        while (a <= e) begin
            int rem = (e - a + 1) / WB;
            int el = (rem < bw) ? rem : bw;
            wait_req("R4 request");
            chk(req_addr == a[AW-1:0], "R4 address", int'(req_addr), a);
            chk(req_len == el[4:0], "R2/R5 length", int'(req_len), el);
            words += int'(req_len);
            a += el * WB;
            if (first && do_mod) apply_mod();
            first = 0;
        end
        chk(words == (e - s + 1) / WB, "R5 total words", words, (e - s + 1) / WB);
        @(negedge clk);
        chk(frame0_done == (kind == 0), "R6 frame0_done", int'(frame0_done), int'(kind == 0));
        chk(frame1_done == (kind == 1), "R6 frame1_done", int'(frame1_done), int'(kind == 1));
        chk(pal_done == (kind == 2), "R9 R10 pal_done", int'(pal_done), int'(kind == 2));
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    task automatic stop_run();
        run = 1'b0;
        quiet(6, "R13 no request after run low");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_valid && !frame0_done && !frame1_done && !pal_done, "R1 reset state", int'(req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid, "R1 after release", int'(req_valid), 0);

        // Sweep burst codes and region sizes, data-only, single buffer
        for (int c = 0; c < 5; c++) begin
            for (int w = 1; w < 10; w++) begin
                int s = 16'h0100 + w * 16'h0040;
                burst_code = c[2:0];
                load_mode = 2'd2;
                dual_en = 1'b0;
                ch0_start = s[AW-1:0];
                ch0_ceil = s[AW-1:0] + AW'(w * WB - 1);
                run = 1'b1;
                chk(!cfg_bad, "R2 legal code", int'(cfg_bad), 0);
                expect_pass(s, s + w * WB - 1, 1 << c, 0, 0);
                wait_req("R7 repeat channel 0");
                chk(req_addr == s[AW-1:0], "R7 single-buffer restarts ch0", int'(req_addr), s);
                stop_run();
            end
        end

        // Dual buffer with reprogramming during passes
        burst_code = 3'd2;
        dual_en = 1'b1;
        ch0_start = 16'h1000; ch0_ceil = 16'h1000 + 16'd19;
        ch1_start = 16'h2000; ch1_ceil = 16'h2000 + 16'd11;
        mod_sel = 1;
        run = 1'b1;
        expect_pass(16'h1000, 16'h1000 + 19, 4, 0, 1);   // R8 active write ignored
        expect_pass(16'h3000, 16'h3000 + 11, 4, 1, 0);   // R7 R8 idle write used
        expect_pass(16'h4000, 16'h4000 + 19, 4, 0, 0);   // R7 R8
        stop_run();
        dual_en = 1'b0;

        // Palette only
        load_mode = 2'd1;
        burst_code = 3'd1;
        ch0_start = 16'h0200; ch0_ceil = 16'h0200 + 16'd23;
        run = 1'b1;
        expect_pass(16'h0200, 16'h0200 + 23, 2, 2, 0);
        quiet(20, "R9 nothing after palette-only pass");
        stop_run();

        // Palette then data, ch0 reprogrammed during palette pass
        load_mode = 2'd0;
        mod_sel = 2;
        run = 1'b1;
        expect_pass(16'h0200, 16'h0200 + 23, 2, 2, 1);
        expect_pass(16'h0800, 16'h0800 + 27, 2, 0, 0);   // R10
        stop_run();

        // Rejected configurations
        load_mode = 2'd2;
        for (int c = 5; c < 8; c++) begin
            burst_code = c[2:0];
            run = 1'b1;
            @(negedge clk);
            chk(cfg_bad, "R3 bad burst code flagged", int'(cfg_bad), 1);
            quiet(12, "R3 bad code no request");
            run = 1'b0;
            @(negedge clk);
        end
        burst_code = 3'd0;
        load_mode = 2'd3;
        run = 1'b1;
        @(negedge clk);
        chk(cfg_bad, "R3 bad load mode flagged", int'(cfg_bad), 1);
        quiet(12, "R3 bad mode no request");
        run = 1'b0;
        load_mode = 2'd2;
        @(negedge clk);

        // FIFO threshold gate
        fifo_thresh = 6'd8;
        fifo_free = 6'd4;
        ch0_start = 16'h0500; ch0_ceil = 16'h0500 + 16'd39;
        run = 1'b1;
        quiet(10, "R12 held below threshold");
        fifo_free = 6'd8;
        wait_req("R12 request at threshold");
        chk(req_addr == 16'h0500, "R12 first address", int'(req_addr), 16'h0500);

        // Backpressure
        req_ready = 1'b0;
        wait_req("R11 request");
        begin
            logic [AW-1:0] a0;
            logic [4:0] l0;
            bit held = 1;
            a0 = req_addr;
            l0 = req_len;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (!req_valid || req_addr != a0 || req_len != l0) held = 0;
            end
            chk(held, "R11 hold under backpressure", int'(held), 1);
        end
        // R13: run low with a request pending; it must complete then stop
        run = 1'b0;
        @(negedge clk);
        chk(req_valid, "R13 pending kept", int'(req_valid), 1);
        req_ready = 1'b1;
        @(negedge clk);
        chk(!req_valid, "R13 pending accepted", int'(req_valid), 0);
        quiet(10, "R13 no new request");
        fifo_thresh = '0;
        fifo_free = '1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule